// File: doc/BRIEF.md
# Synchronous Receiver with Sync-Character Hunt

This block is the receive half of a character-oriented synchronous serial link. It samples the serial data line on each rising edge of the receive bit clock. While it is hunting, it checks the most recently received bits against a programmed sync character after every single bit, so the match can fall at any bit offset. The sync pattern may be one character or two characters in a row. Once the sync pattern is found, the block stops hunting and raises a sync-detected flag. From that point it frames received bits into characters, each with an optional parity bit, and hands each one to the host with a ready flag.

Synchronisation can also come from outside. In external mode the internal comparison is switched off, and a high level on the sync input, held for one system clock cycle, ends the hunt. A host command sends the block back to hunting from any state. A status-read strobe clears the sync-detected flag. A character that arrives before the host has read the previous one replaces it and sets an overrun flag.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset `rxReady`, `syncDetOut`, `overrunErr`, `parityErr` and `rxByte` are all zero and the block is hunting.
- R2: Bits are taken from `rxData` at each rising edge of `rxClk` and arrive least significant bit first. While hunting with `extSync`=0, the last N received bits are compared with the low N bits of `syncChar1` after every bit, so a match is found at any bit offset.
- R3: With `dualSync`=1, after the first sync character matches, the next N bits must equal the low N bits of `syncChar2`. If they do not, no sync is signalled and hunting resumes bit by bit.
- R4: `syncDetOut` goes high when the sync pattern completes and stays high until a `statusRead` pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R5: After sync, every group of N bits that starts with the next received bit forms a character. It appears right-aligned on `rxByte` with the upper bits zero, and `rxReady` goes high. A `dataRead` pulse clears `rxReady`.
- R6: The character length is N = 5 + `charLen` (`charLen` 0..3 gives 5 to 8 bits). The same N applies to the sync characters.
- R7: With `parityEn`=1, one parity bit follows each data character (sync characters carry none). `parityOdd`=0 selects even parity and 1 selects odd. `parityErr` is updated as each character completes.
- R8: If a character completes while `rxReady` is still high, the new byte replaces the old one and `overrunErr` is set.
- R9: With `extSync`=1, no internal match is made. A high level on `syncDetIn` for one clock cycle while hunting ends the hunt and sets `syncDetOut`, and framing starts with the next received bit.
- R10: An `enterHunt` pulse returns the block to hunting from any state and clears `rxReady`, `syncDetOut`, `overrunErr` and `parityErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxClk | input | 1 | Receive bit clock, sampled by clk |
| rxData | input | 1 | Serial receive data |
| syncChar1 | input | 8 | First sync character |
| syncChar2 | input | 8 | Second sync character |
| dualSync | input | 1 | 1: the sync pattern is two characters |
| charLen | input | 2 | Character length code, N = 5 + code |
| parityEn | input | 1 | Enables a parity bit on data characters |
| parityOdd | input | 1 | 1: odd parity, 0: even parity |
| extSync | input | 1 | 1: sync comes from syncDetIn |
| syncDetIn | input | 1 | External sync level |
| enterHunt | input | 1 | Pulse: return to hunting |
| statusRead | input | 1 | Pulse: clears syncDetOut |
| dataRead | input | 1 | Pulse: clears rxReady |
| rxByte | output | 8 | Last received character |
| rxReady | output | 1 | A character is waiting |
| syncDetOut | output | 1 | Sync detected |
| overrunErr | output | 1 | A character was lost |
| parityErr | output | 1 | Parity mismatch on the last character |

## Verification
A bit is taken in the clk cycle in which `rxClk` is first seen high, and its effects are visible after that clock edge. `syncDetOut`, `rxByte`, `rxReady`, `parityErr` and `overrunErr` therefore change one cycle after the edge that samples the final bit of a sync pattern or character. The bench drives each bit as one high and one low system clock of `rxClk`, and it samples flags only after the bit task returns, which is two edges later. A monitor reads each character on the falling clock edge after `rxReady` rises and compares it with a queue filled by the driver. The flag checks, including sync clear, overrun and return to hunt, are made at the falling edge after their stimulus.

// File: rtl/rxsync_pkg.sv
package rxsync_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_SECOND = 2'd1,
    ST_DATA   = 2'd2
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;     // take the current bit into the shift register
    logic clear;       // empty the shift register
    logic loadByte;    // latch a finished character
    logic fromParity;  // the finishing bit is a parity bit
  } dpCtrl_t;

endpackage

// File: rtl/rxsync_datapath.sv
module rxsync_datapath
  import rxsync_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctrl,
  input  logic              rxBit,
  input  logic [CNT_W-1:0]  charBits,
  input  logic [CHAR_W-1:0] syncChar1,
  input  logic [CHAR_W-1:0] syncChar2,
  input  logic              parityOdd,
  output logic              matchSync1,
  output logic              matchSync2,
  output logic              parityBad,
  output logic [CHAR_W-1:0] rxByte
);

  logic [CHAR_W-1:0] shReg;
  logic [CHAR_W-1:0] nextSh;
  logic [CHAR_W-1:0] charMask;
  logic [CHAR_W-1:0] alignedNext;
  logic [CHAR_W-1:0] alignedCur;

  function automatic logic [CHAR_W-1:0] alignChar(input logic [CHAR_W-1:0] v,
                                                  input logic [CNT_W-1:0] n);
    return v >> (CHAR_W - int'(n));
  endfunction

  // newest bit enters at the top; oldest of the last N bits ends at bit 0
  assign nextSh      = {rxBit, shReg[CHAR_W-1:1]};
  assign charMask    = alignChar({CHAR_W{1'b1}}, charBits);
  assign alignedNext = alignChar(nextSh, charBits);
  assign alignedCur  = alignChar(shReg, charBits);

  assign matchSync1 = (alignedNext == (syncChar1 & charMask));
  assign matchSync2 = (alignedNext == (syncChar2 & charMask));
  // received parity bit against the bit the data should carry
  assign parityBad  = rxBit != ((^alignedCur) ^ parityOdd);

  always_ff @(posedge clk) begin
    if (rst || ctrl.clear) begin
      shReg <= '0;
    end else if (ctrl.shiftEn) begin
      shReg <= nextSh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxByte <= '0;
    end else if (ctrl.loadByte) begin
      rxByte <= ctrl.fromParity ? alignedCur : alignedNext;
    end
  end

endmodule

// File: rtl/rxsync_ctrl.sv
module rxsync_ctrl
  import rxsync_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             extSync,
  input  logic             syncDetIn,
  input  logic             enterHunt,
  input  logic             statusRead,
  input  logic             dataRead,
  input  logic             dualSync,
  input  logic             parityEn,
  input  logic [CNT_W-1:0] charBits,
  input  logic             matchSync1,
  input  logic             matchSync2,
  input  logic             parityBad,
  output dpCtrl_t          ctrl,
  output rxState_e         state,
  output logic             syncSet,
  output logic             charDone,
  output logic             rxReady,
  output logic             syncDetOut,
  output logic             overrunErr,
  output logic             parityErr
);

  localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(CHAR_W);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] fill;
  logic [CNT_W-1:0] frameLen;
  logic             fillOk;
  logic             huntMatch;
  logic             extHit;
  logic             secondLast;
  logic             dataLast;

  assign frameLen   = charBits + CNT_W'(parityEn);
  assign fillOk     = (fill + CNT_W'(1)) >= charBits;
  assign huntMatch  = tick && (state == ST_HUNT) && !extSync && fillOk && matchSync1;
  assign extHit     = (state == ST_HUNT) && extSync && syncDetIn;
  assign secondLast = tick && (state == ST_SECOND) && (bitCnt == charBits - CNT_W'(1));
  assign dataLast   = tick && (state == ST_DATA) && (bitCnt == frameLen - CNT_W'(1));

  assign syncSet  = !enterHunt &&
                    ((huntMatch && !dualSync) || (secondLast && matchSync2) || extHit);
  assign charDone = !enterHunt && dataLast;

  always_comb begin
    ctrl            = '0;
    ctrl.clear      = enterHunt;
    ctrl.shiftEn    = tick && !enterHunt && ((state != ST_DATA) || (bitCnt < charBits));
    ctrl.loadByte   = charDone;
    ctrl.fromParity = parityEn;
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (rst || enterHunt) begin
      state  <= ST_HUNT;
      bitCnt <= '0;
      fill   <= '0;
    end else begin
      unique case (state)
        ST_HUNT: begin
          if (extHit) begin
            state  <= ST_DATA;
            bitCnt <= '0;
          end else if (tick) begin
            if (fill != FILL_MAX) fill <= fill + CNT_W'(1);
            if (huntMatch) begin
              state  <= dualSync ? ST_SECOND : ST_DATA;
              bitCnt <= '0;
              fill   <= FILL_MAX;
            end
          end
        end
        ST_SECOND: begin
          if (tick) begin
            if (secondLast) begin
              state  <= matchSync2 ? ST_DATA : ST_HUNT;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + CNT_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            bitCnt <= dataLast ? '0 : bitCnt + CNT_W'(1);
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // host-visible flags
  always_ff @(posedge clk) begin
    if (rst || enterHunt) begin
      rxReady    <= 1'b0;
      syncDetOut <= 1'b0;
      overrunErr <= 1'b0;
      parityErr  <= 1'b0;
    end else begin
      if (charDone)      rxReady <= 1'b1;
      else if (dataRead) rxReady <= 1'b0;

      if (syncSet)         syncDetOut <= 1'b1;
      else if (statusRead) syncDetOut <= 1'b0;

      if (charDone && rxReady && !dataRead) overrunErr <= 1'b1;

      if (charDone) parityErr <= parityEn && parityBad;
    end
  end

endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
  import rxsync_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxClk,
  input  logic              rxData,
  input  logic [CHAR_W-1:0] syncChar1,
  input  logic [CHAR_W-1:0] syncChar2,
  input  logic              dualSync,
  input  logic [LEN_W-1:0]  charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              extSync,
  input  logic              syncDetIn,
  input  logic              enterHunt,
  input  logic              statusRead,
  input  logic              dataRead,
  output logic [CHAR_W-1:0] rxByte,
  output logic              rxReady,
  output logic              syncDetOut,
  output logic              overrunErr,
  output logic              parityErr
);

  localparam int CNT_W    = $clog2(CHAR_W + 2);
  localparam int MIN_BITS = CHAR_W - (1 << LEN_W) + 1;

  logic             rxClkQ;
  logic             tick;
  logic [CNT_W-1:0] charBits;
  dpCtrl_t          ctrl;
  rxState_e         state;
  logic             syncSet;
  logic             charDone;
  logic             matchSync1;
  logic             matchSync2;
  logic             parityBad;

  always_ff @(posedge clk) begin
    if (rst) rxClkQ <= 1'b0;
    else     rxClkQ <= rxClk;
  end

  assign tick     = rxClk && !rxClkQ;
  assign charBits = CNT_W'(MIN_BITS) + CNT_W'(charLen);

  rxsync_ctrl #(.CHAR_W(CHAR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .extSync    (extSync),
    .syncDetIn  (syncDetIn),
    .enterHunt  (enterHunt),
    .statusRead (statusRead),
    .dataRead   (dataRead),
    .dualSync   (dualSync),
    .parityEn   (parityEn),
    .charBits   (charBits),
    .matchSync1 (matchSync1),
    .matchSync2 (matchSync2),
    .parityBad  (parityBad),
    .ctrl       (ctrl),
    .state      (state),
    .syncSet    (syncSet),
    .charDone   (charDone),
    .rxReady    (rxReady),
    .syncDetOut (syncDetOut),
    .overrunErr (overrunErr),
    .parityErr  (parityErr)
  );

  rxsync_datapath #(.CHAR_W(CHAR_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .rxBit      (rxData),
    .charBits   (charBits),
    .syncChar1  (syncChar1),
    .syncChar2  (syncChar2),
    .parityOdd  (parityOdd),
    .matchSync1 (matchSync1),
    .matchSync2 (matchSync2),
    .parityBad  (parityBad),
    .rxByte     (rxByte)
  );

endmodule

// File: rtl/rxsync_checker.sv
module rxsync_checker
  import rxsync_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     enterHunt,
  input logic     statusRead,
  input logic     extSync,
  input logic     syncDetIn,
  input rxState_e state,
  input logic     syncSet,
  input logic     rxReady,
  input logic     syncDetOut,
  input logic     overrunErr
);

  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (statusRead && !syncSet && !enterHunt) |=> !syncDetOut); // R4

  AST_HUNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    enterHunt |=> (state == ST_HUNT && !syncDetOut && !overrunErr && !rxReady)); // R10

  AST_READY_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(rxReady) |-> ($past(state) == ST_DATA)); // R5

  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(overrunErr) |-> $past(rxReady)); // R8

  AST_EXT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (extSync && syncDetIn && state == ST_HUNT && !enterHunt) |=> (state == ST_DATA)); // R9

  AST_SYNC_FROM_HUNT: assert property (@(posedge clk) disable iff (rst)
    $rose(syncDetOut) |-> ($past(state) != ST_DATA)); // R2

endmodule

bind sync_hunt_rx rxsync_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .enterHunt  (enterHunt),
  .statusRead (statusRead),
  .extSync    (extSync),
  .syncDetIn  (syncDetIn),
  .state      (state),
  .syncSet    (syncSet),
  .rxReady    (rxReady),
  .syncDetOut (syncDetOut),
  .overrunErr (overrunErr)
);

// File: tb/sim_sync_hunt_rx.sv
module sim_sync_hunt_rx;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxClk = 1'b0;
  logic       rxData = 1'b1;
  logic [7:0] syncChar1 = 8'h16;
  logic [7:0] syncChar2 = 8'h19;
  logic       dualSync = 1'b0;
  logic [1:0] charLen = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       extSync = 1'b0;
  logic       syncDetIn = 1'b0;
  logic       enterHunt = 1'b0;
  logic       statusRead = 1'b0;
  logic       dataRead = 1'b0;
  logic [7:0] rxByte;
  logic       rxReady;
  logic       syncDetOut;
  logic       overrunErr;
  logic       parityErr;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  bit monitorOn = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_hunt_rx u0 (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    rxData = b;
    rxClk  = 1'b1;
    @(negedge clk);
    rxClk  = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendChar(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) sendBit(v[i]);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
    @(negedge clk);
  endtask

  // scoreboard monitor: compares each delivered character, then reads it
  initial begin
    forever begin
      @(negedge clk);
      if (monitorOn && rxReady && !dataRead) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected character", rxByte, 0);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(rxByte == e, "R5 character value", rxByte, e);
        end
        dataRead = 1'b1;
        @(negedge clk);
        dataRead = 1'b0;
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!rxReady && !syncDetOut && !overrunErr && !parityErr, "R1 flags after reset",
          {rxReady, syncDetOut, overrunErr, parityErr}, 0);
    check(rxByte == 8'h00, "R1 byte after reset", rxByte, 0);

    // R2 bit-offset hunt with one sync character, R5 framing
    sendChar(8'hFF, 3);
    check(!syncDetOut, "R2 no sync on idle bits", syncDetOut, 0);
    sendChar(8'h16, 8);
    check(syncDetOut, "R2 sync found at offset 3", syncDetOut, 1);
    expQ.push_back(8'hA5); sendChar(8'hA5, 8);
    expQ.push_back(8'h3C); sendChar(8'h3C, 8);
    repeat (4) @(negedge clk);
    check(syncDetOut, "R4 sync flag holds", syncDetOut, 1);
    pulse(statusRead);
    check(!syncDetOut, "R4 status read clears sync", syncDetOut, 0);

    // R3 two-character sync, failure then success
    pulse(enterHunt);
    dualSync = 1'b1;
    sendChar(8'h16, 8);
    sendChar(8'hFF, 8);
    check(!syncDetOut, "R3 wrong second character", syncDetOut, 0);
    sendChar(8'h16, 8);
    check(!syncDetOut, "R3 first character alone", syncDetOut, 0);
    sendChar(8'h19, 8);
    check(syncDetOut, "R3 both characters matched", syncDetOut, 1);
    expQ.push_back(8'h5A); sendChar(8'h5A, 8);
    repeat (4) @(negedge clk);

    // R6 five-bit characters
    pulse(enterHunt);
    dualSync = 1'b0;
    charLen  = 2'd0;
    sendChar(8'h16, 5);
    check(syncDetOut, "R6 five-bit sync", syncDetOut, 1);
    expQ.push_back(8'h1B); sendChar(8'h1B, 5);
    expQ.push_back(8'h07); sendChar(8'h07, 5);
    repeat (4) @(negedge clk);

    // R7 parity
    pulse(enterHunt);
    charLen  = 2'd3;
    parityEn = 1'b1;
    sendChar(8'h16, 8);
    expQ.push_back(8'hA5); sendChar(8'hA5, 8); sendBit(1'b0);
    check(!parityErr, "R7 even parity correct", parityErr, 0);
    expQ.push_back(8'h01); sendChar(8'h01, 8); sendBit(1'b0);
    check(parityErr, "R7 even parity wrong", parityErr, 1);
    parityOdd = 1'b1;
    expQ.push_back(8'h03); sendChar(8'h03, 8); sendBit(1'b1);
    check(!parityErr, "R7 odd parity correct", parityErr, 0);
    repeat (4) @(negedge clk);
    parityEn  = 1'b0;
    parityOdd = 1'b0;

    // R8 overrun
    monitorOn = 1'b0;
    pulse(enterHunt);
    sendChar(8'h16, 8);
    sendChar(8'h11, 8);
    check(!overrunErr, "R8 no overrun on first", overrunErr, 0);
    sendChar(8'h22, 8);
    check(overrunErr, "R8 overrun set", overrunErr, 1);
    check(rxByte == 8'h22, "R8 newer byte kept", rxByte, 8'h22);

    // R10 back to hunt
    pulse(enterHunt);
    check(!overrunErr && !rxReady && !syncDetOut, "R10 flags cleared",
          {overrunErr, rxReady, syncDetOut}, 0);
    sendChar(8'h55, 8);
    sendChar(8'h55, 8);
    check(!rxReady && !syncDetOut, "R10 hunting, no framing",
          {rxReady, syncDetOut}, 0);
    monitorOn = 1'b1;

    // R9 external sync
    extSync = 1'b1;
    pulse(enterHunt);
    sendChar(8'h16, 8);
    check(!syncDetOut, "R9 internal compare off", syncDetOut, 0);
    pulse(syncDetIn);
    check(syncDetOut, "R9 external level syncs", syncDetOut, 1);
    expQ.push_back(8'h6E); sendChar(8'h6E, 8);
    repeat (6) @(negedge clk);

    check(expQ.size() == 0, "R5 all characters delivered", expQ.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule